// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core. It has two combinational read ports and one clocked write port. Each port is addressed by a 4-bit register number. A 3-bit operating-mode input decides which physical storage a register number selects. Registers 0–7 and register 15 have one physical copy that every mode shares. The fast-interrupt mode has a private copy of registers 8–12. Every exception mode has its own stack pointer (register 13) and its own link register (register 14).

Each port first translates the register number and the current mode into a physical slot index. It then reads or writes that slot. Switching modes copies no data: only the translation changes. The surrounding pipeline drives the mode on every cycle. Mode sequencing, status words and exception entry are left to that pipeline. Register 15 is stored like any other unbanked register.

Top module: `regbank_file`

## Requirements
- R1: An active-low asynchronous reset clears every physical slot. After reset, every register reads as zero in every mode.
- R2: Registers 0–7 select the same storage in all eight mode codes. A write in any mode is seen by a read of that register in any other mode.
- R3: Registers 8–12 have two copies. Mode code 2 (fast interrupt) uses its own copy. Every other code (0, 1, 3, 4, 5, 6, 7) uses the shared copy.
- R4: Registers 13 and 14 have six copies. Codes 0 (user), 1 (system) and 7 (reserved) share one copy. Codes 2 (fast interrupt), 3 (interrupt), 4 (supervisor), 5 (abort) and 6 (undefined) each have a private copy.
- R5: Register 15 has one copy that is shared by all modes.
- R6: Reads are combinational. A write commits on the rising clock edge. A read in the same cycle as a write to the same register returns the previous value. From the next cycle on, the read returns the new value.
- R7: A write goes to the slot selected by the mode present in its own cycle. Changing the mode moves no stored data.
- R8: When the write enable is low, no slot changes, whatever the write index and write data are.
- R9: The two read ports are independent. Both ports may address the same register, and both then return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all slots |
| mode_i | input | 3 | Operating mode: 0 user, 1 system, 2 fast interrupt, 3 interrupt, 4 supervisor, 5 abort, 6 undefined, 7 treated as user |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Register number written |
| wr_data_i | input | 32 | Write data |
| rd_a_idx_i | input | 4 | Register number for read port A |
| rd_a_data_o | output | 32 | Read port A data, combinational |
| rd_b_idx_i | input | 4 | Register number for read port B |
| rd_b_data_o | output | 32 | Read port B data, combinational |

## Verification
Read data is due in the same cycle as the read index and mode. A written value is due from the first cycle after the rising edge that captured it. The bench drives each cycle's inputs at the falling edge. It compares both read ports one nanosecond later against a reference array that still holds the pre-edge contents. It folds the write into that array only after the following rising edge. This makes a same-cycle read of the written register expect the old value, and the next cycle expect the new one. The reference array keeps one entry per mode and register number. A write is copied into every entry that the requirements say shares storage with it, which checks the banking from outside without rebuilding the slot mapping.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    // Operating mode codes seen on the mode input
    typedef enum logic [2:0] {
        MODE_USER     = 3'd0,
        MODE_SYSTEM   = 3'd1,
        MODE_FAST_IRQ = 3'd2,
        MODE_IRQ      = 3'd3,
        MODE_SUPER    = 3'd4,
        MODE_ABORT    = 3'd5,
        MODE_UNDEF    = 3'd6,
        MODE_RSVD     = 3'd7
    } mode_e;

    localparam int ARCH_W       = 4;
    localparam int NUM_ARCH     = 1 << ARCH_W;
    localparam int SHARED_LAST  = 7;                      // 0..7 always common
    localparam int FAST_FIRST   = 8;
    localparam int FAST_LAST    = 12;
    localparam int FAST_COUNT   = FAST_LAST - FAST_FIRST + 1;
    localparam int PRIV_FIRST   = 13;                     // stack pointer
    localparam int PRIV_LAST    = 14;                     // link register
    localparam int PRIV_COUNT   = PRIV_LAST - PRIV_FIRST + 1;
    localparam int PRIV_BANKS   = 6;                      // user/sys + five exception modes
    localparam int PC_ARCH      = NUM_ARCH - 1;

    // Physical slot layout
    localparam int FAST_BASE    = FAST_LAST + 1;                    // fast copy of 8..12
    localparam int PRIV_BASE    = FAST_BASE + FAST_COUNT;           // banked 13/14 pairs
    localparam int PC_SLOT      = PRIV_BASE + PRIV_BANKS * PRIV_COUNT;
    localparam int NUM_SLOTS    = PC_SLOT + 1;
    localparam int SLOT_W       = $clog2(NUM_SLOTS);
    localparam int BANK_W       = $clog2(PRIV_BANKS);

endpackage

// File: rtl/regbank_map.sv
module regbank_map
    import regbank_pkg::*;
(
    input  logic [2:0]        mode_i,
    input  logic [ARCH_W-1:0] idx_i,
    output logic [SLOT_W-1:0] slot_o
);

    logic [BANK_W-1:0] bank_sel;
    logic              is_fast;
    logic [SLOT_W-1:0] idx_w;

    assign idx_w = SLOT_W'(idx_i);

    // Private bank chosen for registers 13/14
    always_comb begin
        is_fast  = 1'b0;
        bank_sel = '0;
        unique case (mode_e'(mode_i))
            MODE_USER, MODE_SYSTEM, MODE_RSVD: bank_sel = BANK_W'(0);
            MODE_FAST_IRQ: begin
                bank_sel = BANK_W'(1);
                is_fast  = 1'b1;
            end
            MODE_IRQ:      bank_sel = BANK_W'(2);
            MODE_SUPER:    bank_sel = BANK_W'(3);
            MODE_ABORT:    bank_sel = BANK_W'(4);
            MODE_UNDEF:    bank_sel = BANK_W'(5);
        endcase
    end

    always_comb begin
        if (idx_i <= ARCH_W'(SHARED_LAST)) begin
            slot_o = idx_w;
        end else if (idx_i <= ARCH_W'(FAST_LAST)) begin
            slot_o = is_fast ? idx_w + SLOT_W'(FAST_BASE - FAST_FIRST) : idx_w;
        end else if (idx_i <= ARCH_W'(PRIV_LAST)) begin
            slot_o = SLOT_W'(PRIV_BASE)
                   + SLOT_W'(bank_sel) * SLOT_W'(PRIV_COUNT)
                   + (idx_w - SLOT_W'(PRIV_FIRST));
        end else begin
            slot_o = SLOT_W'(PC_SLOT);
        end
    end

endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [SLOT_W-1:0]             wr_slot_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    input  logic [NRD-1:0][SLOT_W-1:0]    rd_slot_i,
    output logic [NRD-1:0][DATA_W-1:0]    rd_data_o
);

    logic [DATA_W-1:0] slot_q [NUM_SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                slot_q[s] <= '0;
            end
        end else if (wr_en_i && (wr_slot_i < SLOT_W'(NUM_SLOTS))) begin
            slot_q[wr_slot_i] <= wr_data_i;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data_o[p] = (rd_slot_i[p] < SLOT_W'(NUM_SLOTS))
                            ? slot_q[rd_slot_i[p]] : '0;
    end

endmodule

// File: rtl/regbank_file.sv
module regbank_file
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o
);

    localparam int NRD = 2;

    logic [NRD-1:0][ARCH_W-1:0] rd_idx;
    logic [NRD-1:0][SLOT_W-1:0] rd_slot;
    logic [NRD-1:0][DATA_W-1:0] rd_data;
    logic [SLOT_W-1:0]          wr_slot;

    assign rd_idx[0]   = rd_a_idx_i;
    assign rd_idx[1]   = rd_b_idx_i;
    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];

    regbank_map u_wr_map (
        .mode_i (mode_i),
        .idx_i  (wr_idx_i),
        .slot_o (wr_slot)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd_map
        regbank_map u_rd_map (
            .mode_i (mode_i),
            .idx_i  (rd_idx[p]),
            .slot_o (rd_slot[p])
        );
    end

    regbank_store #(
        .DATA_W (DATA_W),
        .NRD    (NRD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_slot_i (wr_slot),
        .wr_data_i (wr_data_i),
        .rd_slot_i (rd_slot),
        .rd_data_o (rd_data)
    );

endmodule

// File: rtl/regbank_file_chk.sv
module regbank_file_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic              wr_en_i,
    input logic [3:0]        wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [3:0]        rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [3:0]        rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rd_a_data_o == '0 && rd_b_data_o == '0));

    p_low_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en_i) && rd_a_idx_i <= 4'd7 && $stable(rd_a_idx_i))
        |-> $stable(rd_a_data_o));

    p_upper_common_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en_i) && $stable(rd_a_idx_i)
         && rd_a_idx_i >= 4'd8 && rd_a_idx_i <= 4'd12
         && mode_i != 3'd2 && $past(mode_i) != 3'd2)
        |-> $stable(rd_a_data_o));

    p_pc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en_i) && rd_b_idx_i == 4'd15 && $past(rd_b_idx_i) == 4'd15)
        |-> $stable(rd_b_data_o));

    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && rd_a_idx_i == $past(wr_idx_i)
         && mode_i == $past(mode_i))
        |-> rd_a_data_o == $past(wr_data_i));

    p_ports_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o));

endmodule

bind regbank_file regbank_file_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .rd_a_idx_i  (rd_a_idx_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_idx_i  (rd_b_idx_i),
    .rd_b_data_o (rd_b_data_o)
);

// File: tb/regbank_file_tb.sv
`timescale 1ns/1ps
module regbank_file_tb;

    localparam int DW = 32;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode  = '0;
    logic          we    = 1'b0;
    logic [3:0]    widx  = '0;
    logic [DW-1:0] wdata = '0;
    logic [3:0]    ra    = '0;
    logic [3:0]    rb    = '0;
    logic [DW-1:0] rda, rdb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] mdl [8][16];

    always #2.5 clk = ~clk;

    regbank_file #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_en_i(we),
        .wr_idx_i(widx), .wr_data_i(wdata),
        .rd_a_idx_i(ra), .rd_a_data_o(rda),
        .rd_b_idx_i(rb), .rd_b_data_o(rdb)
    );

    // Storage sharing, written from R2..R5
    function automatic bit same_store(int m1, int m2, int r);
        int a = (m1 == 7) ? 0 : m1;
        int b = (m2 == 7) ? 0 : m2;
        if (r <= 7 || r == 15) return 1'b1;                 // R2, R5
        if (r <= 12) return (a == 2) == (b == 2);           // R3
        if (a <= 1 && b <= 1) return 1'b1;                  // R4 user/system
        return a == b;                                      // R4 private
    endfunction

    task automatic expect_eq(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // One cycle: drive at falling edge, check reads, then apply write to model
    task automatic step(bit w, logic [3:0] wi, logic [DW-1:0] wd,
                        logic [2:0] m, logic [3:0] a, logic [3:0] b, string req);
        @(negedge clk);
        we = w; widx = wi; wdata = wd; mode = m; ra = a; rb = b;
        #1;
        expect_eq(req, $sformatf("port A mode %0d reg %0d", m, a), rda, mdl[m][a]);
        expect_eq(req, $sformatf("port B mode %0d reg %0d", m, b), rdb, mdl[m][b]);
        @(posedge clk);
        if (w) begin
            for (int m2 = 0; m2 < 8; m2++) begin
                if (same_store(int'(m), m2, int'(wi))) mdl[m2][wi] = wd;
            end
        end
    endtask

    task automatic sweep(logic [3:0] r, string req);
        for (int m = 0; m < 8; m++) step(1'b0, 4'd0, '0, 3'(m), r, r, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int m = 0; m < 8; m++)
            for (int r = 0; r < 16; r++) mdl[m][r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        for (int m = 0; m < 8; m++)
            for (int r = 0; r < 16; r += 2) step(1'b0, 4'd0, '0, 3'(m), 4'(r), 4'(r + 1), "R1");

        // R4: stack pointer and link register per mode
        for (int m = 0; m < 7; m++) step(1'b1, 4'd13, 32'hD000_0000 + DW'(m), 3'(m), 4'd0, 4'd1, "R4");
        for (int m = 0; m < 7; m++) step(1'b1, 4'd14, 32'hE100_0000 + DW'(m), 3'(m), 4'd0, 4'd1, "R4");
        sweep(4'd13, "R4");
        sweep(4'd14, "R4");
        step(1'b1, 4'd13, 32'h7777_0007, 3'd7, 4'd13, 4'd14, "R4");
        step(1'b0, 4'd0, '0, 3'd1, 4'd13, 4'd13, "R4");
        step(1'b0, 4'd0, '0, 3'd0, 4'd13, 4'd14, "R4");

        // R3: fast-interrupt copy of 8..12
        for (int r = 8; r <= 12; r++) step(1'b1, 4'(r), 32'hF00D_0000 + DW'(r), 3'd2, 4'd0, 4'd0, "R3");
        for (int r = 8; r <= 12; r++) step(1'b1, 4'(r), 32'hCAFE_0000 + DW'(r), 3'd4, 4'd0, 4'd0, "R3");
        for (int r = 8; r <= 12; r++) sweep(4'(r), "R3");

        // R2 and R5: shared registers
        step(1'b1, 4'd3, 32'h0303_0303, 3'd5, 4'd0, 4'd0, "R2");
        sweep(4'd3, "R2");
        step(1'b1, 4'd15, 32'h1515_1515, 3'd3, 4'd0, 4'd0, "R5");
        sweep(4'd15, "R5");

        // R6: same-cycle read sees old value, next cycle new value
        step(1'b1, 4'd5, 32'hAAAA_5555, 3'd1, 4'd5, 4'd5, "R6");
        step(1'b0, 4'd0, '0, 3'd1, 4'd5, 4'd6, "R6");

        // R7: mode change alone moves nothing
        step(1'b0, 4'd0, '0, 3'd3, 4'd13, 4'd8, "R7");
        step(1'b0, 4'd0, '0, 3'd2, 4'd13, 4'd8, "R7");
        step(1'b0, 4'd0, '0, 3'd3, 4'd13, 4'd8, "R7");

        // R8: disabled write leaves storage untouched
        step(1'b0, 4'd5, 32'hDEAD_BEEF, 3'd1, 4'd5, 4'd5, "R8");
        step(1'b0, 4'd13, 32'hDEAD_BEEF, 3'd2, 4'd5, 4'd13, "R8");
        step(1'b0, 4'd0, '0, 3'd1, 4'd5, 4'd13, "R8");

        // R9 and R7: random traffic
        for (int i = 0; i < 4000; i++) begin
            step(1'($urandom), 4'($urandom), DW'($urandom), 3'($urandom),
                 4'($urandom), 4'($urandom), (i % 2 == 0) ? "R7" : "R9");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule